// File: doc/BRIEF.md
# Ethernet Receive Header Filter

This block watches an 8-bit receive byte stream in which each frame is bracketed by a start marker and an end marker. While the bytes stream past, it captures the header fields it needs and runs two ones'-complement sums. The first sum covers the IPv4 header. The second covers the TCP segment together with its pseudo-header. The block stores no payload.

Shortly after the last byte of a frame, it issues a single-cycle verdict. The verdict says whether the frame belongs to the configured TCP session, or is an ARP message aimed at the local address. It also gives the frame class. The block then holds its ready output low for a fixed gap before it takes the next frame.

A session controller supplies the local and remote addresses and ports. It also supplies the expected receive sequence number, the receive window, and the range of acknowledge numbers that are currently acceptable. A payload splitter downstream uses the verdict to keep or drop the bytes it buffered.

Top module: `rx_hdr_filter`

## Requirements
- R1: Byte offsets count from the start beat, which is offset 0. The fields are placed as follows:
  - destination MAC at 0-5, type at 12-13;
  - IPv4 header at 14-33: version/IHL at 14, total length at 16-17, flags/fragment at 20-21, protocol at 23, checksum at 24-25, source IP at 26-29, destination IP at 30-33;
  - TCP at 34 onward: source port at 34-35, destination port at 36-37, sequence at 38-41, acknowledge at 42-45, data offset in the upper nibble of 46, checksum at 50-51.

  Only type 0x0806 (ARP) and type 0x0800 with protocol 6 (TCP) can be accepted. The class output is 01 for an accepted ARP frame, 10 for an accepted TCP frame, and 00 on any reject.
- R2: A TCP frame is rejected unless byte 14 is 0x45. It is also rejected when the flags/fragment word ANDed with 0x3FFF is nonzero, which covers a set more-fragments bit or a nonzero offset. The don't-fragment bit alone is allowed.
- R3: The TCP data offset must lie between 5 and 15, and the IP total length must be at least 20 plus four times the data offset.
- R4: For TCP, the destination MAC must equal the local MAC. The source and destination IP must equal the remote and local IP, and the source and destination port must equal the remote and local port.
- R5: The ones'-complement sum of the ten IPv4 header words must fold to 0xFFFF.
- R6: The TCP checksum must fold to 0xFFFF. Its sum covers the pseudo-header (both IP addresses, protocol 6, and a TCP length equal to total length minus 20) plus the segment bytes from offset 34 up to 13+total length. An odd last byte is taken as a high byte. Bytes after offset 13+total length are padding and are ignored.
- R7: The sequence number is accepted only if (sequence − expected sequence) mod 2^32 is less than the receive window.
- R8: The acknowledge number is accepted only if (ack − low bound) mod 2^32 is no greater than (high bound − low bound).
- R9: An ARP frame is accepted when all of these hold:
  - the destination MAC is local or broadcast;
  - the opcode at 20-21 is 1 or 2;
  - the target protocol address at 38-41 equals the local IP;
  - at least 42 bytes arrived.
- R10: A frame whose end beat carries the error flag is rejected.
- R11: A frame that ends before 14+total length bytes (TCP) or 42 bytes (ARP) have arrived is rejected.
- R12: Every frame yields exactly one verdict pulse. The pulse is one cycle long and is visible in the second clock cycle after the edge that accepts the end beat.
- R13: After the edge that accepts an end beat, ready stays low for exactly 3 cycles and then returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | Byte valid; held high from start to end of a frame |
| inSop | input | 1 | First byte of a frame |
| inEop | input | 1 | Last byte of a frame |
| inError | input | 1 | Frame error flag, meaningful with inEop |
| outReady | output | 1 | Byte accepted when high together with inValid |
| localMac | input | 48 | Local MAC address |
| localIp | input | 32 | Local IPv4 address |
| remoteIp | input | 32 | Remote IPv4 address |
| localPort | input | 16 | Local TCP port |
| remotePort | input | 16 | Remote TCP port |
| rxNextSeq | input | 32 | Next expected receive sequence number |
| rxWinSize | input | 16 | Receive window in bytes |
| ackLow | input | 32 | Lowest acceptable acknowledge number |
| ackHigh | input | 32 | Highest acceptable acknowledge number |
| verdictValid | output | 1 | One-cycle verdict strobe |
| verdictAccept | output | 1 | Frame accepted |
| verdictClass | output | 2 | 00 none, 01 ARP, 10 TCP |

## Verification
The bench sends clean TCP frames of several shapes:
- with and without options;
- with even and odd payload lengths;
- with Ethernet padding after the IP datagram.

Together these show that the checksum word alignment and the end of the summed range are both right.

Each reject case starts from a good frame and corrupts exactly one field, with both checksums recomputed, so only the rule under test can cause the rejection. Sequence and acknowledge numbers are placed exactly on and one past each bound. ARP frames vary the opcode and the target address. Frames cut one byte short and frames flagged with an error separate the length and error rules from the field checks.

// File: rtl/fh_pkg.sv
`timescale 1ns/1ps
package fh_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic takeByte;
    logic judge;
  } fhStrobe_t;

  typedef enum logic [1:0] {
    FH_NONE = 2'b00,
    FH_ARP  = 2'b01,
    FH_TCP  = 2'b10
  } fhClass_e;

  localparam logic [15:0] TYPE_IPV4 = 16'h0800;
  localparam logic [15:0] TYPE_ARP  = 16'h0806;
  localparam int IP_START  = 14;
  localparam int PSEUDO_START = 26;
  localparam int TCP_START = 34;
  localparam int ARP_MIN_BYTES = 42;
endpackage

// File: rtl/rx_hdr_ctrl.sv
`timescale 1ns/1ps
module rx_hdr_ctrl
  import fh_pkg::*;
#(
  parameter int GAP_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inSop,
  input  logic      inEop,
  output logic      outReady,
  output fhStrobe_t strobe
);
  localparam int CW = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES - 1) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_JUDGE, ST_GAP} ctrlState_e;

  ctrlState_e state;
  logic [CW-1:0] gapCnt;
  logic beat;

  assign outReady = (state == ST_IDLE) || (state == ST_FRAME);
  assign beat     = inValid && outReady;

  always_comb begin
    strobe.startFrame = beat && inSop;
    strobe.takeByte   = beat && (inSop || (state == ST_FRAME));
    strobe.judge      = (state == ST_JUDGE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_FRAME: begin
          if (strobe.takeByte && inEop) state <= ST_JUDGE;
          else if (strobe.startFrame)  state <= ST_FRAME;
        end
        ST_JUDGE: begin
          state  <= ST_GAP;
          gapCnt <= CW'(GAP_CYCLES - 2);
        end
        default: begin
          if (gapCnt == '0) state <= ST_IDLE;
          else gapCnt <= gapCnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_hdr_path.sv
`timescale 1ns/1ps
module rx_hdr_path
  import fh_pkg::*;
#(
  parameter int WIN_W = 16,
  parameter int ACC_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fhStrobe_t        strobe,
  input  logic [7:0]       inData,
  input  logic             inEop,
  input  logic             inError,
  input  logic [47:0]      localMac,
  input  logic [31:0]      localIp,
  input  logic [31:0]      remoteIp,
  input  logic [15:0]      localPort,
  input  logic [15:0]      remotePort,
  input  logic [31:0]      rxNextSeq,
  input  logic [WIN_W-1:0] rxWinSize,
  input  logic [31:0]      ackLow,
  input  logic [31:0]      ackHigh,
  output logic             verdictValid,
  output logic             verdictAccept,
  output fhClass_e         verdictClass
);
  logic [CNT_W-1:0] offset, curOff;
  logic [47:0] macReg;
  logic [15:0] etherType, totalLen, word20, srcPort, dstPort;
  logic [7:0]  verIhl, proto;
  logic [31:0] srcIp, dstIp, seqReg, ackReg;
  logic [3:0]  dataOff;
  logic        errFlag;
  logic [ACC_W-1:0] ipAcc, tcpAcc, wordVal;
  logic [CNT_W:0] tcpEnd;
  logic inIpSum, inTcpSum;

  function automatic logic [15:0] fold(input logic [ACC_W-1:0] a);
    logic [ACC_W:0] s;
    s = {1'b0, a};
    for (int i = 0; i < 3; i++) s = {{(ACC_W-15){1'b0}}, s[15:0]} + (s >> 16);
    return s[15:0];
  endfunction

  assign curOff   = strobe.startFrame ? '0 : offset;
  assign tcpEnd   = (CNT_W+1)'(IP_START) + (CNT_W+1)'(totalLen);
  assign inIpSum  = (curOff >= CNT_W'(IP_START)) && (curOff < CNT_W'(TCP_START));
  assign inTcpSum = (curOff >= CNT_W'(PSEUDO_START)) && ({1'b0, curOff} < tcpEnd);
  // even offsets carry the high byte of a 16-bit word
  assign wordVal  = curOff[0] ? ACC_W'(inData) : ACC_W'({inData, 8'h00});

  // field capture and running sums
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset <= '0;
      ipAcc  <= '0;
      tcpAcc <= '0;
      errFlag <= 1'b0;
      macReg <= '0; etherType <= '0; totalLen <= '0; word20 <= '0;
      verIhl <= '0; proto <= '0; srcIp <= '0; dstIp <= '0;
      srcPort <= '0; dstPort <= '0; seqReg <= '0; ackReg <= '0; dataOff <= '0;
    end else if (strobe.takeByte) begin
      offset  <= (curOff == '1) ? curOff : curOff + CNT_W'(1);
      errFlag <= inEop && inError;
      if (strobe.startFrame) ipAcc <= '0;
      else if (inIpSum) ipAcc <= ipAcc + wordVal;
      if (strobe.startFrame) tcpAcc <= '0;
      else if (inTcpSum) tcpAcc <= tcpAcc + wordVal;
      if (curOff < CNT_W'(6))                             macReg    <= {macReg[39:0], inData};
      if (curOff == CNT_W'(12) || curOff == CNT_W'(13))   etherType <= {etherType[7:0], inData};
      if (curOff == CNT_W'(14))                           verIhl    <= inData;
      if (curOff == CNT_W'(16) || curOff == CNT_W'(17))   totalLen  <= {totalLen[7:0], inData};
      if (curOff == CNT_W'(20) || curOff == CNT_W'(21))   word20    <= {word20[7:0], inData};
      if (curOff == CNT_W'(23))                           proto     <= inData;
      if (curOff >= CNT_W'(26) && curOff < CNT_W'(30))    srcIp     <= {srcIp[23:0], inData};
      if (curOff >= CNT_W'(30) && curOff < CNT_W'(34))    dstIp     <= {dstIp[23:0], inData};
      if (curOff == CNT_W'(34) || curOff == CNT_W'(35))   srcPort   <= {srcPort[7:0], inData};
      if (curOff == CNT_W'(36) || curOff == CNT_W'(37))   dstPort   <= {dstPort[7:0], inData};
      if (curOff >= CNT_W'(38) && curOff < CNT_W'(42))    seqReg    <= {seqReg[23:0], inData};
      if (curOff >= CNT_W'(42) && curOff < CNT_W'(46))    ackReg    <= {ackReg[23:0], inData};
      if (curOff == CNT_W'(46))                           dataOff   <= inData[7:4];
    end
  end

  // verdict evaluation
  logic isArp, isTcp, macLocal, macBcast, arpOk, tcpOk;
  logic ipSumOk, tcpSumOk, seqOk, ackOk, lenOk, addrOk;
  logic [15:0] tcpLen;
  logic [5:0]  hdrBytes;

  always_comb begin
    isArp    = (etherType == TYPE_ARP);
    isTcp    = (etherType == TYPE_IPV4) && (proto == 8'd6);
    macLocal = (macReg == localMac);
    macBcast = (macReg == '1);
    tcpLen   = totalLen - 16'd20;
    hdrBytes = {dataOff, 2'b00};
    ipSumOk  = (fold(ipAcc) == 16'hFFFF);
    tcpSumOk = (fold(tcpAcc + ACC_W'(6) + ACC_W'(tcpLen)) == 16'hFFFF);
    seqOk    = ((seqReg - rxNextSeq) < 32'(rxWinSize));
    ackOk    = ((ackReg - ackLow) <= (ackHigh - ackLow));
    lenOk    = (dataOff >= 4'd5)
            && ({1'b0, totalLen} >= 17'd20 + 17'(hdrBytes))
            && ({1'b0, offset} >= tcpEnd);
    addrOk   = macLocal && (srcIp == remoteIp) && (dstIp == localIp)
            && (srcPort == remotePort) && (dstPort == localPort);
    tcpOk    = isTcp && addrOk && lenOk && (verIhl == 8'h45)
            && ((word20 & 16'h3FFF) == 16'h0000)
            && ipSumOk && tcpSumOk && seqOk && ackOk;
    arpOk    = isArp && (macLocal || macBcast)
            && (word20 == 16'd1 || word20 == 16'd2)
            && (seqReg == localIp)
            && (offset >= CNT_W'(ARP_MIN_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      verdictValid  <= 1'b0;
      verdictAccept <= 1'b0;
      verdictClass  <= FH_NONE;
    end else begin
      verdictValid <= strobe.judge;
      if (strobe.judge) begin
        verdictAccept <= !errFlag && (arpOk || tcpOk);
        if (errFlag)    verdictClass <= FH_NONE;
        else if (arpOk) verdictClass <= FH_ARP;
        else if (tcpOk) verdictClass <= FH_TCP;
        else            verdictClass <= FH_NONE;
      end
    end
  end
endmodule

// File: rtl/rx_hdr_filter.sv
`timescale 1ns/1ps
module rx_hdr_filter
  import fh_pkg::*;
#(
  parameter int WIN_W      = 16,
  parameter int ACC_W      = 32,
  parameter int CNT_W      = 16,
  parameter int GAP_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inSop,
  input  logic             inEop,
  input  logic             inError,
  output logic             outReady,
  input  logic [47:0]      localMac,
  input  logic [31:0]      localIp,
  input  logic [31:0]      remoteIp,
  input  logic [15:0]      localPort,
  input  logic [15:0]      remotePort,
  input  logic [31:0]      rxNextSeq,
  input  logic [WIN_W-1:0] rxWinSize,
  input  logic [31:0]      ackLow,
  input  logic [31:0]      ackHigh,
  output logic             verdictValid,
  output logic             verdictAccept,
  output logic [1:0]       verdictClass
);
  fhStrobe_t strobe;
  fhClass_e  cls;

  rx_hdr_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .outReady(outReady), .strobe(strobe)
  );

  rx_hdr_path #(.WIN_W(WIN_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inEop(inEop),
    .inError(inError), .localMac(localMac), .localIp(localIp), .remoteIp(remoteIp),
    .localPort(localPort), .remotePort(remotePort), .rxNextSeq(rxNextSeq),
    .rxWinSize(rxWinSize), .ackLow(ackLow), .ackHigh(ackHigh),
    .verdictValid(verdictValid), .verdictAccept(verdictAccept), .verdictClass(cls)
  );

  assign verdictClass = cls;
endmodule

// File: rtl/rx_hdr_filter_chk.sv
`timescale 1ns/1ps
module rx_hdr_filter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inEop,
  input logic       inError,
  input logic       outReady,
  input logic       verdictValid,
  input logic       verdictAccept,
  input logic [1:0] verdictClass
);
  logic endBeat;
  assign endBeat = inValid && outReady && inEop;

  AST_VERDICT_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    endBeat |-> ##2 verdictValid);  // R12
  AST_VERDICT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |=> !verdictValid);  // R12
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    endBeat |=> !outReady);  // R13
  AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outReady) |-> ($past(!outReady, 3) && $past(outReady, 4)));  // R13
  AST_ERROR_REJECTS: assert property (@(posedge clk) disable iff (!rstN)
    (endBeat && inError) |-> ##2 (verdictValid && !verdictAccept));  // R10
  AST_CLASS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && verdictAccept) |-> (verdictClass != 2'b00 && verdictClass != 2'b11));  // R1
endmodule

bind rx_hdr_filter rx_hdr_filter_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inEop(inEop), .inError(inError),
  .outReady(outReady), .verdictValid(verdictValid), .verdictAccept(verdictAccept),
  .verdictClass(verdictClass)
);

// File: tb/rx_hdr_filter_bench.sv
`timescale 1ns/1ps
module rx_hdr_filter_bench;
  localparam logic [47:0] L_MAC  = 48'h0200_0000_0001;
  localparam logic [31:0] L_IP   = 32'h0A00_0001;
  localparam logic [31:0] R_IP   = 32'h0A00_0002;
  localparam logic [15:0] L_PORT = 16'h1388;
  localparam logic [15:0] R_PORT = 16'hC000;
  localparam logic [31:0] N_SEQ  = 32'h1000_0000;
  localparam logic [15:0] WIN    = 16'h0800;
  localparam logic [31:0] A_LO   = 32'h2000_0000;
  localparam logic [31:0] A_HI   = 32'h2000_0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0, inError = 1'b0;
  logic outReady, verdictValid, verdictAccept;
  logic [1:0] verdictClass;

  always #4 clk = ~clk;

  rx_hdr_filter u_rx_hdr_filter (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inSop(inSop),
    .inEop(inEop), .inError(inError), .outReady(outReady),
    .localMac(L_MAC), .localIp(L_IP), .remoteIp(R_IP), .localPort(L_PORT),
    .remotePort(R_PORT), .rxNextSeq(N_SEQ), .rxWinSize(WIN), .ackLow(A_LO),
    .ackHigh(A_HI), .verdictValid(verdictValid), .verdictAccept(verdictAccept),
    .verdictClass(verdictClass)
  );

  typedef struct {
    logic acc;
    logic [1:0] cls;
    string tag;
  } exp_t;

  typedef struct {
    logic [47:0] dstMac;
    logic [15:0] ethType;
    logic [7:0]  verIhl;
    logic [15:0] frag;
    logic [7:0]  proto;
    logic [31:0] srcIp, dstIp;
    logic [15:0] srcPort, dstPort;
    logic [31:0] seq, ack;
    logic [3:0]  dataOff;
    int payLen, pad;
    bit badIp, badTcp;
  } knob_t;

  exp_t expQ[$];
  logic [7:0] frm[$];
  int nChecks = 0, nErr = 0, lowRun = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  function automatic knob_t good();
    knob_t k;
    k.dstMac = L_MAC; k.ethType = 16'h0800; k.verIhl = 8'h45; k.frag = 16'h4000;
    k.proto = 8'd6; k.srcIp = R_IP; k.dstIp = L_IP; k.srcPort = R_PORT; k.dstPort = L_PORT;
    k.seq = N_SEQ; k.ack = A_LO + 32'h10; k.dataOff = 4'd5; k.payLen = 0; k.pad = 0;
    k.badIp = 1'b0; k.badTcp = 1'b0;
    return k;
  endfunction

  task automatic put(input logic [47:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) frm.push_back(v[i*8 +: 8]);
  endtask

  function automatic int unsigned sum_range(input int a, input int b);
    int unsigned s = 0;
    for (int i = a; i < b; i++) s += (i % 2 == 0) ? 32'({frm[i], 8'h00}) : 32'(frm[i]);
    return s;
  endfunction

  function automatic logic [15:0] fold16(input int unsigned s0);
    int unsigned s = s0;
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  task automatic build_tcp(input knob_t k);
    int hdrLen, totLen;
    int unsigned s;
    logic [15:0] c;
    hdrLen = (k.dataOff >= 5) ? int'(k.dataOff) * 4 : 20;
    totLen = 20 + hdrLen + k.payLen;
    frm.delete();
    put(k.dstMac, 6); put(48'h0200_0000_0002, 6); put(48'(k.ethType), 2);
    put(48'(k.verIhl), 1); put(48'h0, 1); put(48'(totLen), 2); put(48'h1234, 2);
    put(48'(k.frag), 2); put(48'd64, 1); put(48'(k.proto), 1); put(48'h0, 2);
    put(48'(k.srcIp), 4); put(48'(k.dstIp), 4);
    put(48'(k.srcPort), 2); put(48'(k.dstPort), 2); put(48'(k.seq), 4); put(48'(k.ack), 4);
    put(48'({k.dataOff, 4'h0}), 1); put(48'h18, 1); put(48'h2000, 2); put(48'h0, 2); put(48'h0, 2);
    for (int i = 0; i < hdrLen - 20; i++) put(48'h01, 1);
    for (int i = 0; i < k.payLen; i++) put(48'((i * 7 + 3) & 8'hFF), 1);
    c = ~fold16(sum_range(14, 34));
    if (k.badIp) c = c ^ 16'h0001;
    frm[24] = c[15:8]; frm[25] = c[7:0];
    s = sum_range(34, 14 + totLen) + 32'(k.srcIp[31:16]) + 32'(k.srcIp[15:0])
      + 32'(k.dstIp[31:16]) + 32'(k.dstIp[15:0]) + 32'd6 + 32'(totLen - 20);
    c = ~fold16(s);
    if (k.badTcp) c = c ^ 16'h0100;
    frm[50] = c[15:8]; frm[51] = c[7:0];
    for (int i = 0; i < k.pad; i++) put(48'h0, 1);
  endtask

  task automatic build_arp(input logic [47:0] dst, input logic [15:0] op, input logic [31:0] tpa);
    frm.delete();
    put(dst, 6); put(48'h0200_0000_0002, 6); put(48'h0806, 2);
    put(48'h0001, 2); put(48'h0800, 2); put(48'h06, 1); put(48'h04, 1); put(48'(op), 2);
    put(48'h0200_0000_0002, 6); put(48'(R_IP), 4); put(48'h0, 6); put(48'(tpa), 4);
  endtask

  // driver: queue the expectation, then stream the frame
  task automatic send(input bit err, input logic acc, input logic [1:0] cls, input string tag);
    exp_t e;
    int n;
    e.acc = acc; e.cls = cls; e.tag = tag;
    expQ.push_back(e);
    n = frm.size();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!outReady) @(negedge clk);
      inValid = 1'b1; inData = frm[i]; inSop = (i == 0); inEop = (i == n - 1);
      inError = err && (i == n - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0; inError = 1'b0;
  endtask

  // monitor: compare each verdict with the oldest expectation
  always @(negedge clk) begin
    if (rstN && verdictValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R12", "verdict with no frame pending");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(verdictAccept == e.acc && verdictClass == e.cls, e.tag,
              $sformatf("accept=%0b class=%0d expected accept=%0b class=%0d",
                        verdictAccept, verdictClass, e.acc, e.cls));
      end
    end
  end

  // gap monitor: every low run of ready must be 3 cycles
  always @(negedge clk) begin
    if (rstN) begin
      if (!outReady) lowRun++;
      else if (lowRun > 0) begin
        check(lowRun == 3, "R13", $sformatf("ready low for %0d expected 3", lowRun));
        lowRun = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    knob_t k;
    repeat (3) @(negedge clk);
    check(outReady == 1'b1, "R13", $sformatf("ready in reset=%0b expected 1", outReady));
    check(verdictValid == 1'b0, "R12", $sformatf("verdict in reset=%0b expected 0", verdictValid));
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    k = good(); build_tcp(k); send(0, 1, 2'b10, "R1 plain TCP");
    k = good(); k.dataOff = 4'd7; k.payLen = 5; build_tcp(k); send(0, 1, 2'b10, "R6 options odd payload");
    k = good(); k.payLen = 4; k.pad = 8; build_tcp(k); send(0, 1, 2'b10, "R6 padding ignored");
    k = good(); k.proto = 8'd17; build_tcp(k); send(0, 0, 2'b00, "R1 non-TCP protocol");
    k = good(); k.verIhl = 8'h46; build_tcp(k); send(0, 0, 2'b00, "R2 IHL not 5");
    k = good(); k.frag = 16'h2000; build_tcp(k); send(0, 0, 2'b00, "R2 more-fragments");
    k = good(); k.frag = 16'h0001; build_tcp(k); send(0, 0, 2'b00, "R2 fragment offset");
    k = good(); k.dataOff = 4'd4; build_tcp(k); send(0, 0, 2'b00, "R3 data offset 4");
    k = good(); k.dataOff = 4'd15; build_tcp(k); send(0, 1, 2'b10, "R3 data offset 15");
    k = good(); k.dstMac = 48'h0200_0000_0009; build_tcp(k); send(0, 0, 2'b00, "R4 wrong MAC");
    k = good(); k.srcIp = 32'h0A00_0003; build_tcp(k); send(0, 0, 2'b00, "R4 wrong source IP");
    k = good(); k.dstPort = 16'h1389; build_tcp(k); send(0, 0, 2'b00, "R4 wrong port");
    k = good(); k.badIp = 1'b1; build_tcp(k); send(0, 0, 2'b00, "R5 bad IP checksum");
    k = good(); k.payLen = 3; k.badTcp = 1'b1; build_tcp(k); send(0, 0, 2'b00, "R6 bad TCP checksum");
    k = good(); k.seq = N_SEQ + 32'h7FF; build_tcp(k); send(0, 1, 2'b10, "R7 last window position");
    k = good(); k.seq = N_SEQ + 32'h800; build_tcp(k); send(0, 0, 2'b00, "R7 past window");
    k = good(); k.seq = N_SEQ - 32'h1; build_tcp(k); send(0, 0, 2'b00, "R7 before window");
    k = good(); k.ack = A_HI; build_tcp(k); send(0, 1, 2'b10, "R8 ack high bound");
    k = good(); k.ack = A_HI + 32'h1; build_tcp(k); send(0, 0, 2'b00, "R8 ack above range");
    build_arp(48'hFFFF_FFFF_FFFF, 16'd1, L_IP); send(0, 1, 2'b01, "R9 ARP request broadcast");
    build_arp(L_MAC, 16'd2, L_IP); send(0, 1, 2'b01, "R9 ARP reply");
    build_arp(48'hFFFF_FFFF_FFFF, 16'd3, L_IP); send(0, 0, 2'b00, "R9 ARP bad opcode");
    build_arp(48'hFFFF_FFFF_FFFF, 16'd1, 32'h0A00_0007); send(0, 0, 2'b00, "R9 ARP other target");
    k = good(); build_tcp(k); send(1, 0, 2'b00, "R10 error flag");
    k = good(); k.payLen = 10; build_tcp(k); void'(frm.pop_back()); send(0, 0, 2'b00, "R11 one byte short");
    k = good(); build_tcp(k); while (frm.size() > 30) void'(frm.pop_back()); send(0, 0, 2'b00, "R11 cut in header");
    build_arp(48'hFFFF_FFFF_FFFF, 16'd1, L_IP); void'(frm.pop_back()); send(0, 0, 2'b00, "R11 ARP short");
    k = good(); build_tcp(k); send(0, 1, 2'b10, "R1 recovery after rejects");

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R12", $sformatf("%0d verdicts missing expected 0", expQ.size()));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule